// File: doc/BRIEF.md
# Shared-Buffer Cell Switch Element

This block is an eight-port cell switching element in which every stored cell sits in one common pool of buffer rows. Time is divided into cell cycles of a fixed number of clock ticks. At the last tick of each cell cycle, the element does three things. It moves arriving cells through an input crossbar into free rows. It drains stored cells through an output crossbar to outputs whose downstream neighbour has granted. It presents a fresh upstream grant, which depends on how many rows are still free.

In routed mode each arriving cell carries a destination bitmap. One stored copy then serves one output, several outputs or all of them, and the row is released only when the last pending destination has sent it. In distribution mode the destination field is ignored. Each cell is handed to the next granted output in round-robin order, which spreads load across the outputs. Cells waiting for the same output leave in arrival order. The grant rule keeps the buffer from ever overflowing, so the element never loses a cell.

Top module: `cellsw_elem`

## Requirements
- R1: While reset is asserted and right after it, every `out_valid` bit is low and every `up_gnt` bit is high.
- R2: Transfers happen only on the clock edge where `slot_last` is high, and `slot_last` is high on one tick out of every CELL_TICKS (16 by default). Outputs and the free-row count stay unchanged between these boundaries. A cell accepted at one boundary can leave at the next boundary at the earliest.
- R3: In routed mode, bit o of an input's destination field (field i is `in_dest[i*8 +: 8]`) selects output o. The cell's data appears unchanged on every selected output.
- R4: An output launches a cell only at a boundary where its `down_gnt` bit is high. Otherwise the cell waits in the buffer.
- R5: A multicast row stays stored until each selected output has sent it. A destination that has already been served does not receive the cell a second time.
- R6: For each output, cells leave in the order they arrived. Among cells that arrive at the same boundary, the lower input index counts as older.
- R7: The buffer holds 40 rows. All `up_gnt` bits are high exactly when at least 8 rows (the number of inputs) are free.
- R8: In routed mode, a cell whose destination field is all zeros occupies no row.
- R9: In distribution mode, each arriving cell, taken in input-index order, goes to the first output after the last-used output whose `down_gnt` is high at that boundary. If no output is granted, it goes to the next output in sequence. The pointer starts at output 7 after reset.
- R10: Every accepted cell is delivered exactly once on each of its outputs, including when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_mode | input | 1 | 1 selects distribution mode, 0 selects routed mode |
| in_valid | input | 8 | Per input: a cell is offered at this boundary |
| in_dest | input | 64 | Per input: destination bitmap, 8 bits each |
| in_data | input | 256 | Per input: cell data, 32 bits each |
| up_gnt | output | 8 | Per input: upstream may offer a cell at the next boundary |
| down_gnt | input | 8 | Per output: downstream accepts a cell at this boundary |
| out_valid | output | 8 | Per output: a cell is being sent during this cell cycle |
| out_data | output | 256 | Per output: cell data, 32 bits each |
| slot_last | output | 1 | High on the last tick of each cell cycle |

## Verification
The arrival and departure paths can both act on the same buffer rows at one boundary. The bench provokes this by filling all 40 rows against withheld grants, releasing the grants, and offering eight new cells at the very boundary where rows freed one cell cycle earlier are being reused. It then checks that every output still emits its cells in the exact arrival sequence, with none lost or repeated. A second overlap, grant changes at the same boundary as distribution-mode assignment, is judged by the output each cell appears on.

// File: rtl/swe_pkg.sv
package swe_pkg;
   // index width with a floor of one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/swe_tick.sv
module swe_tick #(
   parameter int TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic last
);
   localparam int TW = swe_pkg::idx_w(TICKS);

   logic [TW-1:0] cnt;

   assign last = (cnt == TW'(TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (last) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/swe_alloc.sv
module swe_alloc #(
   parameter int N    = 8,
   parameter int ROWS = 40
) (
   input  logic                          dist_mode,
   input  logic [N-1:0]                  in_valid,
   input  logic [N*N-1:0]                in_dest,
   input  logic [N-1:0]                  down_gnt,
   input  logic [ROWS-1:0]               occ,
   input  logic [swe_pkg::idx_w(N)-1:0]  rr_q,
   output logic [ROWS-1:0]               wr_en,
   output logic [swe_pkg::idx_w(N)-1:0]  wr_src  [ROWS],
   output logic [N-1:0]                  wr_dest [ROWS],
   output logic [swe_pkg::idx_w(N)-1:0]  rr_d
);
   localparam int SRC_W = swe_pkg::idx_w(N);

   always_comb begin
      logic [ROWS-1:0] taken;
      logic [N-1:0]    dst;
      logic            hit;
      int              ptr;
      int              pick;
      int              slot;
      taken = occ;
      ptr   = int'(rr_q);
      pick  = 0;
      hit   = 1'b0;
      dst   = '0;
      slot  = -1;
      wr_en = '0;
      for (int r = 0; r < ROWS; r++) begin
         wr_src[r]  = '0;
         wr_dest[r] = '0;
      end
      for (int i = 0; i < N; i++) begin
         if (dist_mode) begin
            // next granted output after the pointer, else plain next
            pick = (ptr + 1) % N;
            hit  = 1'b0;
            for (int k = 1; k <= N; k++) begin
               if (!hit && down_gnt[(ptr + k) % N]) begin
                  pick = (ptr + k) % N;
                  hit  = 1'b1;
               end
            end
            dst       = '0;
            dst[pick] = 1'b1;
         end else begin
            dst = in_dest[i*N +: N];
         end
         slot = -1;
         for (int r = 0; r < ROWS; r++) begin
            if (slot < 0 && !taken[r]) slot = r;
         end
         if (in_valid[i] && (dst != '0) && (slot >= 0)) begin
            taken[slot]   = 1'b1;
            wr_en[slot]   = 1'b1;
            wr_src[slot]  = SRC_W'(i);
            wr_dest[slot] = dst;
            if (dist_mode) ptr = pick;
         end
      end
      rr_d = SRC_W'(ptr);
   end
endmodule

// File: rtl/swe_drain.sv
module swe_drain #(
   parameter int N     = 8,
   parameter int ROWS  = 40,
   parameter int AGE_W = 12
) (
   input  logic [N-1:0]                    pend [ROWS],
   input  logic [AGE_W-1:0]                age  [ROWS],
   input  logic [N-1:0]                    down_gnt,
   output logic [N-1:0]                    sel_ok,
   output logic [swe_pkg::idx_w(ROWS)-1:0] sel_row [N],
   output logic [N-1:0]                    clr  [ROWS]
);
   localparam int ROW_W = swe_pkg::idx_w(ROWS);

   always_comb begin
      logic [AGE_W-1:0] best;
      int               bi;
      best = '0;
      bi   = -1;
      for (int r = 0; r < ROWS; r++) clr[r] = '0;
      for (int o = 0; o < N; o++) begin
         bi   = -1;
         best = '0;
         // oldest pending row for this output, lowest row on a tie
         for (int r = 0; r < ROWS; r++) begin
            if (pend[r][o] && (bi < 0 || age[r] > best)) begin
               bi   = r;
               best = age[r];
            end
         end
         sel_ok[o]  = (bi >= 0);
         sel_row[o] = (bi >= 0) ? ROW_W'(bi) : '0;
         if (bi >= 0 && down_gnt[o]) clr[bi][o] = 1'b1;
      end
   end
endmodule

// File: rtl/cellsw_elem.sv
module cellsw_elem #(
   parameter int N          = 8,
   parameter int W          = 32,
   parameter int ROWS       = 40,
   parameter int CELL_TICKS = 16,
   parameter int AGE_W      = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dist_mode,
   input  logic [N-1:0]   in_valid,
   input  logic [N*N-1:0] in_dest,
   input  logic [N*W-1:0] in_data,
   output logic [N-1:0]   up_gnt,
   input  logic [N-1:0]   down_gnt,
   output logic [N-1:0]   out_valid,
   output logic [N*W-1:0] out_data,
   output logic           slot_last
);
   localparam int ROW_W = swe_pkg::idx_w(ROWS);
   localparam int SRC_W = swe_pkg::idx_w(N);
   localparam int CNT_W = $clog2(ROWS + 1);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;
   localparam logic [AGE_W-1:0] AGE_STEP = AGE_W'(N);

   if (N < 2) begin : g_bad_n
      $error("cellsw_elem: N must be at least 2");
   end
   if (ROWS < N) begin : g_bad_rows
      $error("cellsw_elem: ROWS must be at least N");
   end
   if ((1 << AGE_W) <= 4 * N) begin : g_bad_age
      $error("cellsw_elem: AGE_W too narrow for N");
   end
   if (CELL_TICKS < 1) begin : g_bad_ticks
      $error("cellsw_elem: CELL_TICKS must be positive");
   end

   logic [N-1:0]     pend_v [ROWS];
   logic [AGE_W-1:0] age_v  [ROWS];
   logic [W-1:0]     data_v [ROWS];
   logic [ROWS-1:0]  occ;
   logic [ROWS-1:0]  wr_en;
   logic [SRC_W-1:0] wr_src  [ROWS];
   logic [N-1:0]     wr_dest [ROWS];
   logic [N-1:0]     clr     [ROWS];
   logic [N-1:0]     sel_ok;
   logic [ROW_W-1:0] sel_row [N];
   logic [SRC_W-1:0] rr_q, rr_d;
   logic [CNT_W-1:0] free_cnt;

   swe_tick #(.TICKS(CELL_TICKS)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .last (slot_last)
   );

   swe_alloc #(.N(N), .ROWS(ROWS)) u_alloc (
      .dist_mode(dist_mode),
      .in_valid (in_valid),
      .in_dest  (in_dest),
      .down_gnt (down_gnt),
      .occ      (occ),
      .rr_q     (rr_q),
      .wr_en    (wr_en),
      .wr_src   (wr_src),
      .wr_dest  (wr_dest),
      .rr_d     (rr_d)
   );

   swe_drain #(.N(N), .ROWS(ROWS), .AGE_W(AGE_W)) u_drain (
      .pend    (pend_v),
      .age     (age_v),
      .down_gnt(down_gnt),
      .sel_ok  (sel_ok),
      .sel_row (sel_row),
      .clr     (clr)
   );

   // one control slice per buffer row
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [N-1:0]     pend;
      logic [AGE_W-1:0] age;
      logic [W-1:0]     data;

      assign pend_v[r] = pend;
      assign age_v[r]  = age;
      assign data_v[r] = data;
      assign occ[r]    = |pend;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend <= '0;
            age  <= '0;
            data <= '0;
         end else if (slot_last) begin
            if (wr_en[r]) begin
               pend <= wr_dest[r];
               age  <= AGE_W'(N - 1) - AGE_W'(wr_src[r]);
               data <= in_data[int'(wr_src[r])*W +: W];
            end else begin
               pend <= pend & ~clr[r];
               if (occ[r]) age <= (age > AGE_MAX - AGE_STEP) ? AGE_MAX : age + AGE_STEP;
            end
         end
      end
   end

   always_comb begin
      free_cnt = CNT_W'(ROWS);
      for (int r = 0; r < ROWS; r++) begin
         if (occ[r]) free_cnt = free_cnt - 1'b1;
      end
   end

   assign up_gnt = {N{free_cnt >= CNT_W'(N)}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_data  <= '0;
         rr_q      <= SRC_W'(N - 1);
      end else if (slot_last) begin
         rr_q <= rr_d;
         for (int o = 0; o < N; o++) begin
            out_valid[o] <= down_gnt[o] & sel_ok[o];
            if (down_gnt[o] && sel_ok[o]) out_data[o*W +: W] <= data_v[sel_row[o]];
         end
      end
   end
endmodule

// File: rtl/cellsw_elem_chk.sv
module cellsw_elem_chk #(
   parameter int N    = 8,
   parameter int W    = 32,
   parameter int ROWS = 40
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      slot_last,
   input logic [N-1:0]              in_valid,
   input logic [N-1:0]              up_gnt,
   input logic [N-1:0]              down_gnt,
   input logic [N-1:0]              out_valid,
   input logic [N*W-1:0]            out_data,
   input logic [$clog2(ROWS+1)-1:0] free_cnt
);
   localparam int CNT_W = $clog2(ROWS + 1);

   // R4
   grant_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_last |=> ((out_valid & ~$past(down_gnt)) == '0));

   // R2
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_last |=> ($stable(out_valid) && $stable(out_data)));

   // R2
   free_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_last |=> $stable(free_cnt));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_last && !up_gnt[0]) |=> (free_cnt >= $past(free_cnt)));

   // R7
   arrival_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_last && (in_valid != '0)) |-> (free_cnt >= CNT_W'(N)));
endmodule

bind cellsw_elem cellsw_elem_chk #(.N(N), .W(W), .ROWS(ROWS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .slot_last(slot_last),
   .in_valid (in_valid),
   .up_gnt   (up_gnt),
   .down_gnt (down_gnt),
   .out_valid(out_valid),
   .out_data (out_data),
   .free_cnt (free_cnt)
);

// File: tb/sim_cellsw_elem.sv
module sim_cellsw_elem;
   localparam int N = 8;
   localparam int W = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           dist_mode = 1'b0;
   logic [N-1:0]   in_valid = '0;
   logic [N*N-1:0] in_dest = '0;
   logic [N*W-1:0] in_data = '0;
   logic [N-1:0]   up_gnt;
   logic [N-1:0]   down_gnt = '1;
   logic [N-1:0]   out_valid;
   logic [N*W-1:0] out_data;
   logic           slot_last;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   cellsw_elem u0 (
      .clk(clk), .rst_n(rst_n), .dist_mode(dist_mode),
      .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
      .up_gnt(up_gnt), .down_gnt(down_gnt),
      .out_valid(out_valid), .out_data(out_data), .slot_last(slot_last)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual %0d cycles, expected at most 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   // src(3) dest(8) data(32)
   localparam logic [42:0] VEC [6] = '{
      {3'd0, 8'h01, 32'h1111_0001},
      {3'd7, 8'h80, 32'h2222_0002},
      {3'd3, 8'h24, 32'h3333_0003},
      {3'd5, 8'hFF, 32'h4444_0004},
      {3'd2, 8'h10, 32'h5555_0005},
      {3'd6, 8'h81, 32'h6666_0006}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic edge_step();
      do @(negedge clk); while (!slot_last);
      @(negedge clk);
   endtask

   task automatic put(input int i, input logic [N-1:0] dst, input logic [W-1:0] d);
      in_valid[i]       = 1'b1;
      in_dest[i*N +: N] = dst;
      in_data[i*W +: W] = d;
   endtask

   task automatic do_reset();
      in_valid = '0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [W-1:0] fill_word(input int k, input int i);
      return 32'hC000_0000 | W'(k << 8) | W'(i);
   endfunction

   initial begin
      do_reset();
      // R1 reset state
      check("R1 out_valid", 64'(out_valid), 64'h0);
      check("R1 up_gnt", 64'(up_gnt), 64'hFF);

      // R3 routed vectors, R2 one-boundary latency
      for (int v = 0; v < 6; v++) begin
         put(int'(VEC[v][42:40]), VEC[v][39:32], VEC[v][31:0]);
         edge_step();
         in_valid = '0;
         check("R2 no same-boundary exit", 64'(out_valid), 64'h0);
         edge_step();
         check("R3 outputs", 64'(out_valid), 64'(VEC[v][39:32]));
         for (int o = 0; o < N; o++)
            if (VEC[v][32+o]) check("R3 data", 64'(out_data[o*W +: W]), 64'(VEC[v][31:0]));
      end
      edge_step();
      check("R10 no repeat", 64'(out_valid), 64'h0);

      // R4 backpressure
      down_gnt = 8'hFB;
      put(1, 8'h04, 32'hB0B0_0001);
      edge_step();
      in_valid = '0;
      edge_step();
      check("R4 held", 64'(out_valid), 64'h0);
      edge_step();
      check("R4 still held", 64'(out_valid), 64'h0);
      down_gnt = 8'hFF;
      edge_step();
      check("R4 released", 64'(out_valid), 64'h04);
      check("R4 data", 64'(out_data[2*W +: W]), 64'h0000_0000_B0B0_0001);

      // R6 arrival order
      down_gnt = 8'hF7;
      put(4, 8'h08, 32'hD000_0001);
      edge_step();
      in_valid = '0;
      put(1, 8'h08, 32'hD000_0002);
      put(5, 8'h08, 32'hD000_0003);
      edge_step();
      in_valid = '0;
      down_gnt = 8'hFF;
      edge_step();
      check("R6 first", 64'(out_data[3*W +: W]), 64'h0000_0000_D000_0001);
      edge_step();
      check("R6 second", 64'(out_data[3*W +: W]), 64'h0000_0000_D000_0002);
      edge_step();
      check("R6 third", 64'(out_data[3*W +: W]), 64'h0000_0000_D000_0003);
      check("R6 valid", 64'(out_valid), 64'h08);
      edge_step();
      check("R6 drained", 64'(out_valid), 64'h0);

      // R5 multicast with partial grant
      put(2, 8'h03, 32'hABCD_0005);
      edge_step();
      in_valid = '0;
      down_gnt = 8'hFD;
      edge_step();
      check("R5 first leg", 64'(out_valid), 64'h01);
      check("R5 first data", 64'(out_data[0 +: W]), 64'h0000_0000_ABCD_0005);
      down_gnt = 8'hFF;
      edge_step();
      check("R5 second leg", 64'(out_valid), 64'h02);
      check("R5 second data", 64'(out_data[W +: W]), 64'h0000_0000_ABCD_0005);
      edge_step();
      check("R5 row freed", 64'(out_valid), 64'h0);

      // R7 R8 R10 fill, then overlap of arrival and departure
      down_gnt = 8'h00;
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < N; i++) put(i, 8'(1 << i), fill_word(k, i));
         edge_step();
         in_valid = '0;
      end
      check("R7 32 stored, grant kept", 64'(up_gnt), 64'hFF);
      for (int i = 0; i < N; i++) put(i, 8'h00, 32'hDEAD_0000);
      edge_step();
      in_valid = '0;
      check("R8 empty dest stores nothing", 64'(up_gnt), 64'hFF);
      for (int i = 0; i < N; i++) put(i, 8'(1 << i), fill_word(4, i));
      edge_step();
      in_valid = '0;
      check("R7 full, grant withdrawn", 64'(up_gnt), 64'h00);
      check("R4 no grant, no output", 64'(out_valid), 64'h0);
      down_gnt = 8'hFF;
      edge_step();
      check("R7 grant back", 64'(up_gnt), 64'hFF);
      for (int i = 0; i < N; i++) check("R10 drain 0", 64'(out_data[i*W +: W]), 64'(fill_word(0, i)));
      for (int i = 0; i < N; i++) put(i, 8'(1 << i), fill_word(5, i));
      for (int k = 1; k <= 5; k++) begin
         edge_step();
         in_valid = '0;
         check("R10 all valid", 64'(out_valid), 64'hFF);
         for (int i = 0; i < N; i++) check("R10 R6 drain order", 64'(out_data[i*W +: W]), 64'(fill_word(k, i)));
      end
      edge_step();
      check("R10 empty", 64'(out_valid), 64'h0);
      check("R7 empty grant", 64'(up_gnt), 64'hFF);

      // R9 distribution mode
      do_reset();
      check("R1 second reset", 64'(out_valid), 64'h0);
      dist_mode = 1'b1;
      down_gnt  = 8'hFF;
      put(0, 8'h00, 32'hE000_0000);
      put(1, 8'h00, 32'hE000_0001);
      put(2, 8'h00, 32'hE000_0002);
      edge_step();
      in_valid = '0;
      edge_step();
      check("R9 spread", 64'(out_valid), 64'h07);
      check("R9 out1", 64'(out_data[W +: W]), 64'h0000_0000_E000_0001);
      down_gnt = 8'h22;
      put(3, 8'h01, 32'hE000_0003);
      edge_step();
      in_valid = '0;
      put(0, 8'h01, 32'hE000_0004);
      edge_step();
      in_valid = '0;
      check("R9 granted after pointer", 64'(out_valid), 64'h20);
      check("R9 out5 data", 64'(out_data[5*W +: W]), 64'h0000_0000_E000_0003);
      edge_step();
      check("R9 wrap", 64'(out_valid), 64'h02);
      check("R9 out1 data", 64'(out_data[W +: W]), 64'h0000_0000_E000_0004);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule